// File: doc/BRIEF.md
# Packed-Lane Integer Multiply-Add Unit

This execution unit takes sub-word lanes from 32-bit register operands, multiplies them, adds a full 32-bit third operand and, if asked, shifts the sum right by a fixed amount. Operand A is always a register value. Operand B is either a register value or a 16-bit immediate. Each register operand goes through its own lane picker. The picker selects one of four bytes, or the low or high halfword.

One control flag per operand marks it as signed. If either flag is set, the whole operation is signed: the lanes are sign-extended, the post-add shift is arithmetic, and only the immediate follows its own flag. A request is given by one cycle of `in_valid` together with the operand and control fields. One clock later, either the registered result appears with `out_valid`, or `out_err` is raised because a lane code was not legal.

Top module: `lane_mac_unit`

## Requirements
- R1: With a lane's byte flag set, the lane is bits [8*i+7 : 8*i] of the operand, where i is the 2-bit byte index (0 selects bits 7:0, 3 selects bits 31:24).
- R2: With the byte flag clear, lane code 0 selects bits 15:0 and lane code 1 selects bits 31:16.
- R3: With the byte flag clear, lane code 2 (full word) and lane code 3 (undefined) are illegal. This applies to A, and to B when B comes from a register. An illegal request gives `out_err`=1 and `out_valid`=0 one clock later, and `result` keeps its previous value.
- R4: When `b_from_reg`=0, B is the 16-bit immediate. It is sign-extended if `b_signed`=1 and zero-extended otherwise. The B lane fields then have no effect, and an illegal code in them raises no error.
- R5: The operation is signed when `a_signed` or `b_signed` is 1. A signed operation sign-extends register lanes from their lane width. An unsigned operation zero-extends them.
- R6: The pre-shift value is A×B + `c_val`, taken modulo 2^32.
- R7: `shift_sel` 0 and 3 leave the value unshifted. Code 1 shifts right by 7 and code 2 shifts right by 15. The shift is arithmetic for a signed operation and logical for an unsigned one.
- R8: `out_valid` or `out_err` is high for exactly the one cycle after an `in_valid` cycle. Without `in_valid`, both stay low and `result` holds.
- R9: During reset, `out_valid`, `out_err` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| a_val | input | 32 | Register operand A |
| b_val | input | 32 | Register operand B |
| c_val | input | 32 | Addend |
| imm_val | input | 16 | Immediate used for B |
| b_from_reg | input | 1 | 1: B from register, 0: from immediate |
| a_signed | input | 1 | A signed flag |
| b_signed | input | 1 | B signed flag |
| a_byte | input | 1 | A byte-lane mode |
| a_kind | input | 2 | A halfword lane code |
| a_idx | input | 2 | A byte index |
| b_byte | input | 1 | B byte-lane mode |
| b_kind | input | 2 | B halfword lane code |
| b_idx | input | 2 | B byte index |
| shift_sel | input | 2 | Post-add shift code |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Illegal lane code flag |
| result | output | 32 | Registered result |

## Verification
The bench goes after the cases where sign handling is easy to get wrong. A design that extends lanes by their own flag instead of the combined signedness gives the wrong product when only one flag is set. A design that always shifts arithmetically turns an unsigned 0xFFFE0001 shifted by 15 into a negative-looking value instead of 0x1FFFC. A design that checks the B lane code while B is the immediate raises a false `out_err`. A design that updates `result` on an illegal request loses the held value. A wraparound case, where the sum reaches exactly 2^32, shows whether the add is truncated to 32 bits.

// File: rtl/lane_mac_unit.sv
module lane_mac_unit #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] a_val,
  input  logic [DW-1:0] b_val,
  input  logic [DW-1:0] c_val,
  input  logic [IW-1:0] imm_val,
  input  logic          b_from_reg,
  input  logic          a_signed,
  input  logic          b_signed,
  input  logic          a_byte,
  input  logic [1:0]    a_kind,
  input  logic [1:0]    a_idx,
  input  logic          b_byte,
  input  logic [1:0]    b_kind,
  input  logic [1:0]    b_idx,
  input  logic [1:0]    shift_sel,
  output logic          out_valid,
  output logic          out_err,
  output logic [DW-1:0] result
);
  localparam int BW = DW / 4;
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] BMASK = {{(DW-BW){1'b0}}, {BW{1'b1}}};
  localparam logic [DW-1:0] HMASK = {{(DW-HW){1'b0}}, {HW{1'b1}}};
  localparam logic [1:0] K_LO = 2'd0;
  localparam logic [1:0] S_7 = 2'd1;
  localparam logic [1:0] S_15 = 2'd2;

  function automatic logic [DW-1:0] pick_lane(input logic [DW-1:0] src, input logic bmode,
                                               input logic [1:0] kind, input logic [1:0] idx,
                                               input logic sx);
    logic [DW-1:0] t;
    if (bmode) begin
      t = (src >> (int'(idx) * BW)) & BMASK;
      if (sx && t[BW-1]) t = t | ~BMASK;
    end else begin
      t = (kind == K_LO) ? (src & HMASK) : (src >> HW);
      if (sx && t[HW-1]) t = t | ~HMASK;
    end
    return t;
  endfunction

  logic          sx;
  logic          bad;
  logic [DW-1:0] a_op, b_op, sum, shifted;

  assign sx   = a_signed | b_signed;
  assign bad  = (!a_byte && a_kind[1]) || (b_from_reg && !b_byte && b_kind[1]);
  assign a_op = pick_lane(a_val, a_byte, a_kind, a_idx, sx);
  assign b_op = b_from_reg ? pick_lane(b_val, b_byte, b_kind, b_idx, sx)
              : {{(DW-IW){b_signed & imm_val[IW-1]}}, imm_val};
  assign sum  = a_op * b_op + c_val;

  always_comb begin
    case (shift_sel)
      S_7:     shifted = sx ? DW'($signed(sum) >>> 7)  : (sum >> 7);
      S_15:    shifted = sx ? DW'($signed(sum) >>> 15) : (sum >> 15);
      default: shifted = sum;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid && !bad;
      out_err   <= in_valid && bad;
      if (in_valid && !bad) result <= shifted;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_err && $stable(result)); // R8
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid || out_err); // R8
  AST_FULL_A_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !a_byte && a_kind[1] |=> out_err && $stable(result)); // R3
  AST_IMM_NO_B_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !b_from_reg && (a_byte || !a_kind[1]) |=> out_valid); // R4
endmodule

// File: tb/test_lane_mac_unit.sv
module test_lane_mac_unit;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] a_val = '0, b_val = '0, c_val = '0;
  logic [15:0] imm_val = '0;
  logic b_from_reg = 0, a_signed = 0, b_signed = 0, a_byte = 0, b_byte = 0;
  logic [1:0] a_kind = 0, a_idx = 0, b_kind = 0, b_idx = 0, shift_sel = 0;
  logic out_valid, out_err;
  logic [31:0] result;
  int errors = 0, checks = 0;
  logic [31:0] last_res = '0;

  always #4 clk = ~clk;

  lane_mac_unit i_lane_mac_unit (.*);

  typedef struct packed {
    logic [31:0] a, b, c; logic [15:0] imm;
    logic breg, asg, bsg, ab; logic [1:0] ak, ai;
    logic bb; logic [1:0] bk, bi, sh;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'hA1B2C3D4, 32'h05060708, 32'h0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd3, 1'b1, 2'd0, 2'd1, 2'd0},
    '{32'hA1B2C3D4, 32'h05060708, 32'h10, 16'h0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 1'b1, 2'd0, 2'd3, 2'd0},
    '{32'h80007FFF, 32'h00020000, 32'h3, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd1, 2'd0, 2'd0},
    '{32'h80007FFF, 32'h00020000, 32'h3, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 2'd1, 2'd0, 2'd0},
    '{32'h00000005, 32'h0, 32'h0, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{32'h00000005, 32'h0, 32'h0, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{32'hFFFF0000, 32'h0000FFFF, 32'h0001FFFF, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{32'h0000F000, 32'h0, 32'h0, 16'h0100, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd2},
    '{32'h0000F000, 32'h0, 32'h12345, 16'h0100, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd3},
    '{32'h11111111, 32'h2, 32'h0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1, 2'd0, 2'd0, 2'd0},
    '{32'h11111111, 32'h2, 32'h0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 2'd3, 2'd0, 2'd0},
    '{32'h00000009, 32'h0, 32'h1, 16'h0007, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 2'd3, 2'd0, 2'd1}
  };

  function automatic longint lane_of(logic [31:0] s, logic bm, logic [1:0] k, logic [1:0] i, logic sx);
    longint v;
    if (bm) begin
      v = longint'((s >> (i * 8)) & 32'hFF);
      if (sx && v >= 128) v = v - 256;
    end else begin
      v = (k == 2'd0) ? longint'(s[15:0]) : longint'(s[31:16]);
      if (sx && v >= 32768) v = v - 65536;
    end
    return v;
  endfunction

  function automatic logic [32:0] model(vec_t v);
    logic sx = v.asg | v.bsg;
    longint av, bv;
    logic [31:0] r;
    if ((!v.ab && v.ak >= 2) || (v.breg && !v.bb && v.bk >= 2)) return {1'b1, 32'h0};
    av = lane_of(v.a, v.ab, v.ak, v.ai, sx);
    if (v.breg) bv = lane_of(v.b, v.bb, v.bk, v.bi, sx);
    else bv = (v.bsg && v.imm >= 16'h8000) ? longint'(v.imm) - 65536 : longint'(v.imm);
    r = 32'(av * bv + longint'(v.c));
    if (v.sh == 2'd1) r = sx ? 32'(int'(r) >>> 7) : r >> 7;
    else if (v.sh == 2'd2) r = sx ? 32'(int'(r) >>> 15) : r >> 15;
    return {1'b0, r};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(negedge clk);
    {a_val, b_val, c_val, imm_val} = {v.a, v.b, v.c, v.imm};
    {b_from_reg, a_signed, b_signed, a_byte, a_kind, a_idx} = {v.breg, v.asg, v.bsg, v.ab, v.ak, v.ai};
    {b_byte, b_kind, b_idx, shift_sel} = {v.bb, v.bk, v.bi, v.sh};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_vec(string req, vec_t v);
    logic [32:0] e = model(v);
    apply(v);
    if (e[32]) begin
      chk({req, " err"}, {31'b0, out_err}, 32'd1);
      chk({req, " valid"}, {31'b0, out_valid}, 32'd0);
      chk({req, " hold"}, result, last_res);
    end else begin
      chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
      chk({req, " err"}, {31'b0, out_err}, 32'd0);
      chk({req, " value"}, result, e[31:0]);
      last_res = e[31:0];
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R9 valid", {31'b0, out_valid}, 32'd0);
    chk("R9 err", {31'b0, out_err}, 32'd0);
    chk("R9 result", result, 32'd0);
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) begin
      string tag;
      case (n)
        0, 1: tag = "R1";   2, 3: tag = "R2";   4, 5, 11: tag = "R4";
        6: tag = "R6";      7, 8: tag = "R7";   default: tag = "R3";
      endcase
      run_vec(tag, VEC[n]);
    end

    // R1 hand value: byte 2 unsigned times high half, plus 5
    v = '{32'h11223344, 32'hAABBCCDD, 32'h5, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2, 1'b0, 2'd1, 2'd0, 2'd0};
    apply(v);
    chk("R1 hand", result, 32'h0016ACDB);
    // R5/R7: -1 * 3 = -3, arithmetic shift by 7 gives -1
    v = '{32'h000000FF, 32'h0, 32'h0, 16'h0003, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd1};
    apply(v);
    chk("R5 signed shr7", result, 32'hFFFFFFFF);
    // R5: b_signed alone makes A byte 0xFF read as -1
    v = '{32'h000000FF, 32'h00000002, 32'h0, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b1, 2'd0, 2'd0, 2'd0};
    apply(v);
    chk("R5 either flag", result, 32'hFFFFFFFE);
    // R7: unsigned logical shift by 15
    v = '{32'h0000FFFF, 32'h0, 32'h0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd2};
    apply(v);
    chk("R7 logical", result, 32'h0001FFFC);
    last_res = 32'h0001FFFC;
    // R8: idle cycles produce nothing and hold result
    repeat (3) begin
      @(negedge clk);
      chk("R8 idle valid", {31'b0, out_valid}, 32'd0);
      chk("R8 idle err", {31'b0, out_err}, 32'd0);
      chk("R8 idle hold", result, last_res);
    end
    // R3 after a good result: illegal A keeps value
    v = '{32'h1, 32'h1, 32'h1, 16'h1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0};
    apply(v);
    chk("R3 invalid code err", {31'b0, out_err}, 32'd1);
    chk("R3 invalid code hold", result, 32'h0001FFFC);
    @(negedge clk);
    chk("R8 err one cycle", {31'b0, out_err}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule